// File: doc/BRIEF.md
# Subcode Serial Master

This block is a master-only synchronous serial port for pulling subcode and status words out of a disc servo controller. It drives a serial clock, a data output and two slave-select outputs, and it reads a single data input. Software places a command word, the number of command bits to send, the number of response bits to collect, the target select and a clock divisor on the inputs, then pulses `start`.

The block first shifts out the command bits, most significant bit first. It then shifts the response bits into a 96-bit register, where they end up right-aligned. The send and receive lengths are independent: from 0 to 32 bits out and from 0 to 96 bits in. Output data changes when the serial clock falls and input data is sampled when it rises. Each select line has its own active level.

When a transfer ends, the select goes back to its idle level and stays there for one full serial clock period. Only after that is `done` raised, so two back-to-back transfers are always separated.

Top module: `subcode_spi_master`

## Requirements
- R1: Whenever `busy` is low, `sclk` is low and every select output `ss[i]` sits at its idle level, which is `~sel_pol[i]`. After reset, `busy` and `done` are both low.
- R2: The send phase presents the lowest `tx_len` bits of `tx_word` (0 to 32) on `mosi`, most significant of those bits first, one bit per `sclk` rising edge.
- R3: After the transfer, the last `rx_len` bits sampled from `miso` (0 to 96) sit in `rx_word[rx_len-1:0]`, with the first received bit the most significant. All bits above them are zero.
- R4: A transfer produces exactly `tx_len + rx_len` rising edges of `sclk`, and the receive bits follow all of the send bits. A transfer with both counts at zero produces no clock edges.
- R5: Each high phase and each low phase of `sclk` lasts `div + 1` system clocks, which makes the serial period `2*(div+1)` system clocks.
- R6: `mosi` changes only while `sclk` is low or as `sclk` falls. It never changes while `sclk` stays high.
- R7: `sel` = 0 selects `ss[0]` and `sel` = 1 selects `ss[1]`. The selected output is held at `sel_pol[sel]` from the first clock bit through the last falling edge. The other select never goes active.
- R8: After the last bit, the select is idle for `2*(div+1)` system clocks before `done` rises, and `busy` stays high during that gap.
- R9: `done` rises at the end of a transfer and clears when the next accepted `start` arrives. A `start` seen while `busy` is high is ignored and does not disturb the running transfer.
- R10: During the receive phase, `mosi` is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer when idle |
| tx_word | input | 32 | Command bits, right-aligned |
| tx_len | input | 6 | Number of bits to send, 0 to 32 |
| rx_len | input | 7 | Number of bits to receive, 0 to 96 |
| sel | input | 1 | Target select index |
| sel_pol | input | 2 | Active level of each select output |
| div | input | 8 | Half-period of the serial clock, minus one, in system clocks |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss | output | 2 | Slave-select outputs |
| busy | output | 1 | Transfer or idle gap in progress |
| done | output | 1 | Last transfer finished |
| rx_word | output | 96 | Received bits, right-aligned |

## Verification
The bench goes after the length corners: zero bits sent, zero bits received, both zero, a single bit each way, and the full 32 and 96. An engine that adds the two counts wrongly or shifts by the wrong amount would clip the command or misalign the response. It measures every clock phase and the idle gap in system clocks, so a divider that is off by one, or a gap that is too short, shows up as a wrong count. It also fires a second `start` with different command data in the middle of a transfer. A block that accepted that pulse would send corrupted bits or restart.

// File: rtl/subcode_spi_master.sv
module subcode_spi_master #(
  parameter int TX_MAX = 32,
  parameter int RX_MAX = 96,
  parameter int DIV_W  = 8,
  parameter int NSEL   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [TX_MAX-1:0]             tx_word,
  input  logic [$clog2(TX_MAX+1)-1:0]   tx_len,
  input  logic [$clog2(RX_MAX+1)-1:0]   rx_len,
  input  logic [$clog2(NSEL)-1:0]       sel,
  input  logic [NSEL-1:0]               sel_pol,
  input  logic [DIV_W-1:0]              div,
  input  logic                          miso,
  output logic                          sclk,
  output logic                          mosi,
  output logic [NSEL-1:0]               ss,
  output logic                          busy,
  output logic                          done,
  output logic [RX_MAX-1:0]             rx_word
);
  localparam int TXC_W = $clog2(TX_MAX+1);
  localparam int SEL_W = $clog2(NSEL);
  localparam int BIT_W = $clog2(TX_MAX+RX_MAX+1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GUARD} state_t;

  state_t             st;
  logic [DIV_W-1:0]   hcnt, div_q;
  logic [BIT_W-1:0]   bitn, total_q, txn_q;
  logic [TX_MAX-1:0]  tx_sh;
  logic [RX_MAX-1:0]  rx_sh;
  logic [SEL_W-1:0]   sel_q;
  logic               gph;

  wire              half_end = (hcnt == div_q);
  wire              in_tx    = (bitn < txn_q);
  wire [BIT_W-1:0]  req_tot  = BIT_W'(tx_len) + BIT_W'(rx_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; hcnt <= '0; div_q <= '0; bitn <= '0; total_q <= '0;
      txn_q <= '0; tx_sh <= '0; rx_sh <= '0; sel_q <= '0; gph <= 1'b0;
      sclk <= 1'b0; done <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          done    <= 1'b0;
          div_q   <= div;
          hcnt    <= '0;
          bitn    <= '0;
          gph     <= 1'b0;
          total_q <= req_tot;
          txn_q   <= BIT_W'(tx_len);
          tx_sh   <= tx_word << (TXC_W'(TX_MAX) - tx_len);
          rx_sh   <= '0;
          sel_q   <= sel;
          sclk    <= 1'b0;
          st      <= (req_tot == '0) ? S_GUARD : S_SHIFT;
        end
        S_SHIFT: if (half_end) begin
          hcnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            if (!in_tx) rx_sh <= {rx_sh[RX_MAX-2:0], miso};
          end else begin
            sclk  <= 1'b0;
            bitn  <= bitn + 1'b1;
            tx_sh <= tx_sh << 1;
            if (bitn == total_q - 1'b1) st <= S_GUARD;
          end
        end else hcnt <= hcnt + 1'b1;
        S_GUARD: if (half_end) begin
          hcnt <= '0;
          gph  <= ~gph;
          if (gph) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end else hcnt <= hcnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mosi    = (st == S_SHIFT) && in_tx && tx_sh[TX_MAX-1];
  assign busy    = (st != S_IDLE);
  assign rx_word = rx_sh;

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    assign ss[i] = (st == S_SHIFT && sel_q == SEL_W'(i)) ? sel_pol[i] : ~sel_pol[i];
  end
endmodule

module subcode_spi_master_chk #(
  parameter int NSEL = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sclk,
  input logic            mosi,
  input logic [NSEL-1:0] ss,
  input logic [NSEL-1:0] sel_pol,
  input logic            busy,
  input logic            done
);
  a_r1_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  a_r1_idle_selects: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ss == ~sel_pol));

  a_r6_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r7_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ss ^ ~sel_pol) <= 1);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  a_r9_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done);
endmodule

bind subcode_spi_master subcode_spi_master_chk #(.NSEL(NSEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .ss(ss),
  .sel_pol(sel_pol), .busy(busy), .done(done)
);

// File: tb/test_subcode_spi_master.sv
module test_subcode_spi_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tx_word = '0;
  logic [5:0]  tx_len = '0;
  logic [6:0]  rx_len = '0;
  logic        sel = 1'b0;
  logic [1:0]  sel_pol = 2'b00;
  logic [7:0]  div = '0;
  logic        miso = 1'b0;
  logic        sclk, mosi, busy, done;
  logic [1:0]  ss;
  logic [95:0] rx_word;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  subcode_spi_master i_subcode_spi_master (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .tx_len(tx_len),
    .rx_len(rx_len), .sel(sel), .sel_pol(sel_pol), .div(div), .miso(miso),
    .sclk(sclk), .mosi(mosi), .ss(ss), .busy(busy), .done(done), .rx_word(rx_word)
  );

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] w, input int tl, input int rl, input int d,
                      input bit s, input logic [1:0] pol, input logic [95:0] resp, input bit poke);
    int rises = 0, hi_run = 0, hi_bad = 0, mosi_bad = 0, rxz_bad = 0;
    int ss_bad = 0, last_act = -1, done_at = -1, cyc = 0;
    logic [31:0] got = '0;
    logic [95:0] mask;
    logic [31:0] tmask;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;
    mask  = (96'd1 << rl) - 96'd1;
    tmask = (tl == 32) ? 32'hFFFF_FFFF : ((32'd1 << tl) - 32'd1);
    @(negedge clk);
    tx_word = w; tx_len = 6'(tl); rx_len = 7'(rl); div = 8'(d); sel = s; sel_pol = pol;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: the accepted start clears done
    chk(!done && busy, "R9 start clears done", {94'd0, done, busy}, 96'd1);
    while (done_at < 0 && cyc < 4000) begin
      if (rises >= tl && rises < tl + rl) miso = resp[rl - 1 - (rises - tl)];
      else miso = 1'b0;
      if (poke && rises == 3) begin
        tx_word = ~w; tx_len = 6'd5; start = 1'b1;
      end else begin
        tx_word = w; tx_len = 6'(tl); start = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (sclk && !prev_sclk) begin
        if (rises < tl) got = {got[30:0], mosi};
        else if (mosi) rxz_bad++;
        rises++;
        hi_run = 1;
      end else if (sclk) hi_run++;
      if (!sclk && prev_sclk && hi_run != d + 1) hi_bad++;
      if (sclk && prev_sclk && mosi != prev_mosi) mosi_bad++;
      if (ss[!s] != ~pol[!s]) ss_bad++;
      if (ss[s] == pol[s]) last_act = cyc;
      if (sclk && ss[s] != pol[s]) ss_bad++;
      if (done) done_at = cyc;
      prev_sclk = sclk; prev_mosi = mosi;
    end
    start = 1'b0; tx_word = w; tx_len = 6'(tl);
    chk(rises == tl + rl, "R4 clock edge count", 96'(rises), 96'(tl + rl));
    chk(got == (w & tmask), "R2 sent bits", {64'd0, got}, {64'd0, w & tmask});
    chk(rx_word == (resp & mask), "R3 received word", rx_word, resp & mask);
    chk(hi_bad == 0, "R5 sclk phase length", 96'(hi_bad), 96'd0);
    chk(mosi_bad == 0, "R6 mosi steady while sclk high", 96'(mosi_bad), 96'd0);
    chk(rxz_bad == 0, "R10 mosi low in receive phase", 96'(rxz_bad), 96'd0);
    chk(ss_bad == 0, "R7 select levels", 96'(ss_bad), 96'd0);
    if (tl + rl > 0)
      chk(done_at - last_act == 2 * (d + 1) + 1, "R8 idle gap before done",
          96'(done_at - last_act), 96'(2 * (d + 1) + 1));
    else
      chk(last_act < 0 && done_at == 2 * (d + 1), "R4 empty transfer",
          96'(done_at), 96'(2 * (d + 1)));
    chk(done && !busy, "R9 done at end", {94'd0, done, busy}, 96'd2);
    chk(!sclk && ss == ~pol, "R1 idle after transfer", {93'd0, sclk, ss}, {94'd0, ~pol});
  endtask

  initial begin
    int tls[4] = '{0, 1, 7, 32};
    int rls[4] = '{0, 1, 13, 96};
    int it = 0;
    repeat (3) @(negedge clk);
    sel_pol = 2'b10;
    @(negedge clk);
    // R1: reset state
    chk(!sclk && !busy && !done && ss == 2'b01, "R1 reset state",
        {92'd0, sclk, busy, done, ss[0]}, 96'd1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 2; c++) begin
          xfer(32'hA5C3_1E69 ^ (32'(it) * 32'h0101_0F0F), tls[a], rls[b], c * 2,
               it[0] ^ it[2], 2'(it >> 1),
               {32'h9E37_79B9, 32'h7F4A_7C15, 32'hC2B2_AE35} ^ (96'(it) << 40), 1'b0);
          it++;
        end
    // R9: start while busy must be ignored
    xfer(32'h1234_5678, 32, 20, 1, 1'b1, 2'b11, 96'hDEAD_BEEF_0BAD_F00D_CAFE, 1'b1);
    xfer(32'h8000_0001, 32, 96, 0, 1'b0, 2'b01, {3{32'h5555_AAAA}}, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule